// File: doc/BRIEF.md
# Set-Associative Victim Way Selector

This block decides which way of a cache set is given up when a new block has to be placed in that set. The cache controller presents the set index with the valid and dirty bits of every way in that set. The block answers in the same cycle with a victim way index and a flag that tells whether the victim holds modified data that must be written to memory first. Usage history is kept inside the block, one record per set, and is updated from two sources. A hit notification names the way that was used. An allocate request marks the selected victim as used, because that victim is filled in the same cycle.

Candidates are ranked in three tiers. Ways holding no data are taken first. When a static configuration input asks for it, valid but unmodified ways come next, so that the eviction costs no write-back. Otherwise, or when every way is modified, the least recently used way is taken. Associativity is a parameter restricted to 2 or 4. A 2-way set keeps a single most-recently-used bit. A 4-way set keeps a 2-bit age for each way.

Top module: `victim_way_selector`

## Requirements
- R1: If any way of the addressed set has valid = 0, the victim is the lowest-numbered such way, and the write-back flag is 0.
- R2: If all ways are valid and the clean-preference input is 0, the victim is the least recently used way of the addressed set.
- R3: The parameter WAYS selects 2-way or 4-way sets, and R1 to R9 hold for both. Within a set, the usage history always ranks every way at a distinct position.
- R4: If all ways are valid, clean preference is 1 and at least one way has dirty = 0, the victim is the least recently used among the ways with dirty = 0, and the write-back flag is 0.
- R5: The write-back flag is 1 exactly when the chosen victim has valid = 1 and dirty = 1. Dirty bits on invalid ways never raise it.
- R6: A hit notification with no allocate in that cycle makes the named way the most recently used of the addressed set at the next clock edge. All other sets keep their history.
- R7: An allocate request makes the victim shown in that cycle the most recently used way of the addressed set. If a hit notification arrives in the same cycle, the allocate takes priority and the hit is ignored.
- R8: After reset, every set ranks its ways in index order: way 0 is least recently used and way WAYS-1 is most recently used.
- R9: The victim and the flag depend combinationally on the current set index, valid bits, dirty bits and stored history, with no added cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prefer_clean_i | input | 1 | Static mode: prefer unmodified ways over pure LRU |
| set_idx_i | input | $clog2(SETS) | Addressed set, for both lookup and update |
| way_valid_i | input | WAYS | Valid bit of each way in the addressed set |
| way_dirty_i | input | WAYS | Dirty bit of each way in the addressed set |
| alloc_i | input | 1 | Allocate: the shown victim is filled this cycle |
| touch_i | input | 1 | Hit notification for the addressed set |
| touch_way_i | input | $clog2(WAYS) | Way that hit |
| victim_way_o | output | $clog2(WAYS) | Selected victim way |
| victim_wb_o | output | 1 | Victim must be written back before reuse |

## Verification
The assertions assume that the clean-preference input does not change while a set's history is read. They also assume that the valid and dirty bits describe the addressed set in the same cycle as the index. The bench holds the mode constant for the length of each phase. It drives set index, bits and requests together at the falling edge, so every comparison sees one coherent snapshot. Random stimulus deliberately sets dirty bits on invalid ways and issues allocates together with hits, because R5 and R7 must still hold in those cases.

// File: rtl/vws_pkg.sv
package vws_pkg;

  localparam int MAX_WAYS = 4;

  typedef logic [1:0] age_t;
  typedef age_t [MAX_WAYS-1:0] age_vec_t;

  typedef enum logic [1:0] {
    TIER_EMPTY = 2'd0,
    TIER_CLEAN = 2'd1,
    TIER_LRU   = 2'd2
  } tier_e;

  // Accessed way becomes age 0; ways younger than it age by one.
  function automatic age_vec_t age_touch(age_vec_t a, logic [1:0] w);
    age_vec_t r;
    r = a;
    for (int j = 0; j < MAX_WAYS; j++) begin
      if (a[j] < a[w]) r[j] = a[j] + 2'd1;
    end
    r[w] = 2'd0;
    return r;
  endfunction

  // Oldest way among those with a set mask bit.
  function automatic logic [1:0] oldest_in(age_vec_t a, logic [MAX_WAYS-1:0] m);
    logic [1:0] r;
    logic       found;
    age_t       best;
    r     = 2'd0;
    found = 1'b0;
    best  = 2'd0;
    for (int i = 0; i < MAX_WAYS; i++) begin
      if (m[i] && (!found || a[i] > best)) begin
        found = 1'b1;
        best  = a[i];
        r     = 2'(i);
      end
    end
    return r;
  endfunction

  // Lowest index with a set mask bit.
  function automatic logic [1:0] first_set(logic [MAX_WAYS-1:0] m);
    logic [1:0] r;
    r = 2'd0;
    for (int i = MAX_WAYS - 1; i >= 0; i--) begin
      if (m[i]) r = 2'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/vws_lru_store.sv
module vws_lru_store
  import vws_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set_i,
  output age_vec_t         rd_ages_o,
  input  logic             wr_en_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  age_vec_t         wr_ages_i
);

  generate
    if (WAYS == 2) begin : g_two
      logic [SETS-1:0] mru_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mru_q <= '1;
        end else if (wr_en_i) begin
          mru_q[wr_set_i] <= (wr_ages_i[1] == 2'd0);
        end
      end

      always_comb begin
        rd_ages_o    = '0;
        rd_ages_o[0] = mru_q[rd_set_i] ? 2'd1 : 2'd0;
        rd_ages_o[1] = mru_q[rd_set_i] ? 2'd0 : 2'd1;
      end
    end else begin : g_four
      age_vec_t age_q [SETS];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++) begin
            for (int i = 0; i < MAX_WAYS; i++) begin
              age_q[s][i] <= 2'(MAX_WAYS - 1 - i);
            end
          end
        end else if (wr_en_i) begin
          age_q[wr_set_i] <= wr_ages_i;
        end
      end

      assign rd_ages_o = age_q[rd_set_i];
    end
  endgenerate

endmodule

// File: rtl/vws_pick.sv
module vws_pick
  import vws_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  age_vec_t          ages_i,
  input  logic [WAYS-1:0]   valid_i,
  input  logic [WAYS-1:0]   dirty_i,
  input  logic              prefer_clean_i,
  output logic [1:0]        way_o,
  output logic              wb_o,
  output tier_e             tier_o
);

  logic [MAX_WAYS-1:0] live, vmask, dmask, empty_m, clean_m;

  always_comb begin
    live               = '0;
    live[WAYS-1:0]     = '1;
    vmask              = '0;
    vmask[WAYS-1:0]    = valid_i;
    dmask              = '0;
    dmask[WAYS-1:0]    = dirty_i;
    empty_m            = live & ~vmask;
    clean_m            = live & ~dmask;

    if (|empty_m) begin
      way_o  = first_set(empty_m);
      tier_o = TIER_EMPTY;
    end else if (prefer_clean_i && (|clean_m)) begin
      way_o  = oldest_in(ages_i, clean_m);
      tier_o = TIER_CLEAN;
    end else begin
      way_o  = oldest_in(ages_i, live);
      tier_o = TIER_LRU;
    end

    wb_o = vmask[way_o] & dmask[way_o];
  end

endmodule

// File: rtl/victim_way_selector.sv
module victim_way_selector
  import vws_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prefer_clean_i,
  input  logic [SET_W-1:0] set_idx_i,
  input  logic [WAYS-1:0]  way_valid_i,
  input  logic [WAYS-1:0]  way_dirty_i,
  input  logic             alloc_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_way_o,
  output logic             victim_wb_o
);

  // Named internal events used by the checker.
  age_vec_t   rd_ages;
  age_vec_t   new_ages;
  logic [1:0] pick_way;
  tier_e      pick_tier;
  logic       use_evt;
  logic [1:0] use_way;

  vws_lru_store #(
    .WAYS (WAYS),
    .SETS (SETS)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_set_i  (set_idx_i),
    .rd_ages_o (rd_ages),
    .wr_en_i   (use_evt),
    .wr_set_i  (set_idx_i),
    .wr_ages_i (new_ages)
  );

  vws_pick #(
    .WAYS (WAYS)
  ) u_pick (
    .ages_i         (rd_ages),
    .valid_i        (way_valid_i),
    .dirty_i        (way_dirty_i),
    .prefer_clean_i (prefer_clean_i),
    .way_o          (pick_way),
    .wb_o           (victim_wb_o),
    .tier_o         (pick_tier)
  );

  assign use_evt      = alloc_i | touch_i;
  assign use_way      = alloc_i ? pick_way : 2'(touch_way_i);
  assign new_ages     = age_touch(rd_ages, use_way);
  assign victim_way_o = pick_way[WAY_W-1:0];

endmodule

// File: rtl/vws_checker.sv
module vws_checker
  import vws_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prefer_clean_i,
  input logic [WAYS-1:0]  way_valid_i,
  input logic [WAYS-1:0]  way_dirty_i,
  input logic [WAY_W-1:0] victim_way_o,
  input logic             victim_wb_o,
  input age_vec_t         rd_ages
);

  logic [MAX_WAYS-1:0] seen;
  logic [WAYS-1:0]     below;
  logic                v_valid, v_dirty;

  always_comb begin
    seen = '0;
    for (int i = 0; i < WAYS; i++) seen[rd_ages[i]] = 1'b1;
    below = '0;
    for (int i = 0; i < WAYS; i++) below[i] = (i < int'(victim_way_o));
    v_valid = way_valid_i[victim_way_o];
    v_dirty = way_dirty_i[victim_way_o];
  end

  AST_EMPTY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(&way_valid_i) |-> !v_valid); // R1
  AST_EMPTY_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    !(&way_valid_i) |-> ((way_valid_i & below) == below)); // R1
  AST_AGES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == WAYS); // R3
  AST_CLEAN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (prefer_clean_i && (&way_valid_i) && !(&way_dirty_i)) |-> !victim_wb_o); // R4
  AST_WB_IMPLIES_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    victim_wb_o |-> (v_valid && v_dirty)); // R5
  AST_DIRTY_IMPLIES_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (v_valid && v_dirty) |-> victim_wb_o); // R5

endmodule

bind victim_way_selector vws_checker #(
  .WAYS (WAYS),
  .SETS (SETS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .prefer_clean_i (prefer_clean_i),
  .way_valid_i    (way_valid_i),
  .way_dirty_i    (way_dirty_i),
  .victim_way_o   (victim_way_o),
  .victim_wb_o    (victim_wb_o),
  .rd_ages        (rd_ages)
);

// File: tb/victim_way_selector_tb.sv
module victim_way_selector_tb;

  localparam int SETS = 8;
  localparam int SW   = $clog2(SETS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pc = 1'b0;
  logic [SW-1:0] set_i = '0;
  logic [3:0]    v = '0, d = '0;
  logic          al = 1'b0, tc = 1'b0;
  logic [1:0]    tw = '0;
  logic [1:0]    vic4;
  logic          wb4;
  logic [0:0]    vic2;
  logic          wb2;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  victim_way_selector #(.WAYS(4), .SETS(SETS)) u_dut (
    .clk(clk), .rst_n(rst_n), .prefer_clean_i(pc), .set_idx_i(set_i),
    .way_valid_i(v), .way_dirty_i(d), .alloc_i(al), .touch_i(tc),
    .touch_way_i(tw), .victim_way_o(vic4), .victim_wb_o(wb4));

  // R3: the 2-way variant sees the low two bits of the same stimulus.
  victim_way_selector #(.WAYS(2), .SETS(SETS)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .prefer_clean_i(pc), .set_idx_i(set_i),
    .way_valid_i(v[1:0]), .way_dirty_i(d[1:0]), .alloc_i(al), .touch_i(tc),
    .touch_way_i(tw[0]), .victim_way_o(vic2), .victim_wb_o(wb2));

  // Reference model: per set, a list of ways from least to most recently used.
  int ord [2][SETS][4];

  function automatic int nw(int k);
    return (k == 0) ? 4 : 2;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++)
      for (int s = 0; s < SETS; s++)
        for (int p = 0; p < 4; p++) ord[k][s][p] = p;
  endtask

  task automatic model_use(int k, int s, int w);
    int p;
    p = 0;
    for (int q = 0; q < nw(k); q++) if (ord[k][s][q] == w) p = q;
    for (int q = p; q < nw(k) - 1; q++) ord[k][s][q] = ord[k][s][q + 1];
    ord[k][s][nw(k) - 1] = w;
  endtask

  task automatic model_pick(int k, int s, output int w, output bit wb, output string tag);
    bit done;
    done = 0;
    w = ord[k][s][0];
    tag = "R2";
    for (int i = 0; i < nw(k); i++)
      if (!done && !v[i]) begin w = i; tag = "R1"; done = 1; end
    if (!done && pc)
      for (int q = 0; q < nw(k); q++)
        if (!done && !d[ord[k][s][q]]) begin w = ord[k][s][q]; tag = "R4"; done = 1; end
    wb = v[w] && d[w];
    if (wb) tag = {tag, "/R5"};
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, compare mid-low phase (R9), update model after the edge.
  task automatic step(int s, logic [3:0] vv, logic [3:0] dd, bit a, bit t, int w, string ctx);
    int    ew [2];
    bit    ewb [2];
    string tg [2];
    int    aw, awb;
    @(negedge clk);
    set_i = SW'(s); v = vv; d = dd; al = a; tc = t; tw = 2'(w);
    #5;
    for (int k = 0; k < 2; k++) begin
      model_pick(k, s, ew[k], ewb[k], tg[k]);
      aw  = (k == 0) ? int'(vic4) : int'(vic2);
      awb = (k == 0) ? int'(wb4) : int'(wb2);
      check(aw == ew[k] && awb == int'(ewb[k]), {tg[k], " ", ctx, (k ? " 2-way R3" : " 4-way R3")},
            "victim*2+wb", aw * 2 + awb, ew[k] * 2 + int'(ewb[k]));
    end
    for (int k = 0; k < 2; k++) begin
      if (a) model_use(k, s, ew[k]);               // R7 allocate wins
      else if (t) model_use(k, s, w % nw(k));      // R6 hit
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R8: index order after reset, every set.
    for (int s = 0; s < SETS; s++) step(s, 4'hF, 4'h0, 0, 0, 0, "R8 reset order");

    // R1: lowest invalid way, dirty on invalid ignored (R5).
    step(1, 4'b1010, 4'b0101, 0, 0, 0, "R1 lowest invalid");
    step(1, 4'b1101, 4'b0010, 0, 0, 0, "R1 middle invalid");
    step(1, 4'b0111, 4'b1000, 0, 0, 0, "R1 top invalid");

    // R6: hits reorder set 2 only.
    step(2, 4'hF, 4'h0, 0, 1, 0, "R6 hit way0");
    step(2, 4'hF, 4'h0, 0, 1, 1, "R6 hit way1");
    step(2, 4'hF, 4'h0, 0, 0, 0, "R6 lru after hits");
    step(3, 4'hF, 4'h0, 0, 0, 0, "R6 other set untouched");

    // R7: allocate with simultaneous hit; allocate wins.
    step(4, 4'hF, 4'hF, 1, 1, 3, "R7 alloc beats hit");
    step(4, 4'hF, 4'hF, 0, 0, 0, "R7 after alloc");

    // R4: clean preference.
    pc = 1'b1;
    step(5, 4'hF, 4'b0011, 0, 0, 0, "R4 oldest clean");
    step(5, 4'hF, 4'b1111, 0, 0, 0, "R4 all dirty falls to LRU R5");
    step(5, 4'hF, 4'b1101, 1, 0, 0, "R4 alloc the clean one");
    step(5, 4'hF, 4'b1100, 0, 0, 0, "R4 next clean");

    // Random phases, mode constant within each.
    for (int ph = 0; ph < 2; ph++) begin
      pc = ph[0];
      for (int n = 0; n < 3000; n++) begin
        logic [3:0] rv;
        rv = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
        step($urandom_range(0, SETS - 1), rv, 4'($urandom), $urandom_range(0, 3) == 0,
             $urandom_range(0, 1) == 1, $urandom_range(0, 3), "random");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule